// File: doc/BRIEF.md
# ALU Status Flag Generator

This block sits beside an 8-bit adder/subtractor datapath and produces the arithmetic result together with five status flags: sign, zero, nibble carry, even parity and carry. It accepts two operands, a 3-bit operation code, a carry/borrow input and an update enable. The result is combinational. The flags are captured into a flag register only on clock edges where the update enable is high.

The flags are packed into one byte with a fixed layout, so that surrounding logic can push, test or restore them as a unit. Subtraction reuses the adder through operand inversion. For subtraction the two carry flags report borrows instead of carries. Operation codes outside the arithmetic set pass operand A straight through and report only its sign, zero and parity.

Top module: `alu_flag_gen`

## Requirements
- R1: Synchronous active-high reset sets the flag byte to 0x02. Reset takes priority over an update enable in the same cycle.
- R2: Op code 0 (add) gives result = A + B mod 256 and ignores the carry input. The carry flag (bit 0) is 1 when the sum exceeds 255; 0xC0 + 0x80 gives result 0x40 with carry 1.
- R3: Op code 1 (add with carry) adds the carry input as a third term. Carry and nibble carry use all three terms.
- R4: For add operations the nibble-carry flag (bit 4) is 1 when the low nibbles plus any carry-in exceed 15; 0x08 + 0x08 sets it.
- R5: Op code 2 (subtract) gives A − B. Op code 3 (subtract with borrow) gives A − B − carry input. Carry (bit 0) is 1 when a borrow leaves the MSB (A < B + borrow-in). Nibble carry (bit 4) is 1 when the low nibble needs a borrow (A[3:0] < B[3:0] + borrow-in).
- R6: The parity flag (bit 2) is 1 when the result has an even number of ones, and 0 when the count is odd.
- R7: The zero flag (bit 6) is 1 exactly when the 8-bit result is 0x00.
- R8: The sign flag (bit 7) equals the result MSB.
- R9: Op codes 4 to 7 (pass-through) give result = A, clear carry and nibble carry, and derive sign, zero and parity from A.
- R10: On a clock edge with the update enable low, the flag byte keeps its value whatever the other inputs do.
- R11: Flag-byte bits 5 and 3 always read 0 and bit 1 always reads 1.
- R12: The flags for an operation appear on the flag output after the clock edge that captures them, not before. The result output follows the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code (0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4-7 pass A) |
| opa_i | input | 8 | Operand A |
| opb_i | input | 8 | Operand B |
| cin_i | input | 1 | Carry-in for op 1, borrow-in for op 3 |
| upd_i | input | 1 | Flag update enable |
| res_o | output | 8 | Combinational result |
| flags_o | output | 8 | Registered flag byte {S,Z,0,AC,0,P,1,CY} |

## Verification
Two functions can fall in the same cycle. A flag capture can meet a reset. A hold (enable low) can meet an operation that would change every flag. The bench raises reset together with the update enable while applying 0xC0 + 0x80, and expects 0x02 after the edge. It then presents borrow-producing and zero-producing operations with the enable low, and judges them at the ports: the result output must show the new operation while the flag byte stays at its earlier value.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADC  = 3'd1,
        OP_SUB  = 3'd2,
        OP_SBB  = 3'd3,
        OP_PASS = 3'd4
    } alu_op_e;

    localparam int FLAG_W   = 8;
    localparam int FB_SIGN  = 7;
    localparam int FB_ZERO  = 6;
    localparam int FB_AUX   = 4;
    localparam int FB_PAR   = 2;
    localparam int FB_ONE   = 1;
    localparam int FB_CARRY = 0;

    localparam logic [FLAG_W-1:0] FLAG_RST = 8'h02;

    typedef struct packed {
        logic sign;
        logic zero;
        logic aux;
        logic par;
        logic carry;
    } flags_t;

    typedef struct packed {
        logic sub;
        logic use_cin;
        logic pass;
    } op_ctl_t;

    function automatic op_ctl_t decode_op(input logic [2:0] code);
        op_ctl_t c;
        c.pass    = code[2];
        c.sub     = !code[2] && code[1];
        c.use_cin = !code[2] && code[0];
        return c;
    endfunction

    function automatic logic [FLAG_W-1:0] pack_flags(input flags_t f);
        logic [FLAG_W-1:0] b;
        b           = '0;
        b[FB_SIGN]  = f.sign;
        b[FB_ZERO]  = f.zero;
        b[FB_AUX]   = f.aux;
        b[FB_PAR]   = f.par;
        b[FB_ONE]   = 1'b1;
        b[FB_CARRY] = f.carry;
        return b;
    endfunction

endpackage

// File: rtl/alu_flag_adder.sv
module alu_flag_adder #(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              carry_o,
    output logic              aux_o
);
    localparam int HI_W = DATA_W - NIB_W;

    logic [DATA_W-1:0] b_eff;
    logic              c_in_eff;
    logic [NIB_W:0]    lo_sum;
    logic [HI_W:0]     hi_sum;

    always_comb begin
        b_eff    = sub_i ? ~b_i : b_i;
        c_in_eff = sub_i ? ~cin_i : cin_i;
        lo_sum   = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]}
                 + {{NIB_W{1'b0}}, c_in_eff};
        hi_sum   = {1'b0, a_i[DATA_W-1:NIB_W]} + {1'b0, b_eff[DATA_W-1:NIB_W]}
                 + {{HI_W{1'b0}}, lo_sum[NIB_W]};
        sum_o    = {hi_sum[HI_W-1:0], lo_sum[NIB_W-1:0]};
        // a borrow is the inverse of the carry out of a + ~b + ~bin
        carry_o  = hi_sum[HI_W] ^ sub_i;
        aux_o    = lo_sum[NIB_W] ^ sub_i;
    end
endmodule

// File: rtl/alu_flag_eval.sv
module alu_flag_eval
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] res_i,
    input  logic              carry_i,
    input  logic              aux_i,
    output logic [FLAG_W-1:0] flags_o
);
    flags_t f;

    always_comb begin
        f.sign  = res_i[DATA_W-1];
        f.zero  = (res_i == '0);
        f.aux   = aux_i;
        f.par   = ~(^res_i);
        f.carry = carry_i;
        flags_o = pack_flags(f);
    end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg #(
    parameter int               W       = 8,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         en_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i)
            q_o <= RST_VAL;
        else if (en_i)
            q_o <= d_i;
    end
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [2:0]          op_i,
    input  logic [DATA_W-1:0]   opa_i,
    input  logic [DATA_W-1:0]   opb_i,
    input  logic                cin_i,
    input  logic                upd_i,
    output logic [DATA_W-1:0]   res_o,
    output logic [FLAG_W-1:0]   flags_o
);
    op_ctl_t           ctl;
    logic [DATA_W-1:0] arith_sum;
    logic              arith_cy;
    logic              arith_ac;
    logic              sel_cy;
    logic              sel_ac;
    logic [FLAG_W-1:0] next_flags;

    always_comb ctl = decode_op(op_i);

    alu_flag_adder #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_add (
        .a_i     (opa_i),
        .b_i     (opb_i),
        .sub_i   (ctl.sub),
        .cin_i   (ctl.use_cin & cin_i),
        .sum_o   (arith_sum),
        .carry_o (arith_cy),
        .aux_o   (arith_ac)
    );

    always_comb begin
        res_o  = ctl.pass ? opa_i : arith_sum;
        sel_cy = ctl.pass ? 1'b0  : arith_cy;
        sel_ac = ctl.pass ? 1'b0  : arith_ac;
    end

    alu_flag_eval #(.DATA_W(DATA_W)) u_eval (
        .res_i   (res_o),
        .carry_i (sel_cy),
        .aux_i   (sel_ac),
        .flags_o (next_flags)
    );

    alu_flag_reg #(.W(FLAG_W), .RST_VAL(FLAG_RST)) u_reg (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .en_i  (upd_i),
        .d_i   (next_flags),
        .q_o   (flags_o)
    );
endmodule

// File: rtl/alu_flag_gen_chk.sv
module alu_flag_gen_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [2:0]        op_i,
    input logic              upd_i,
    input logic [DATA_W-1:0] opa_i,
    input logic [DATA_W-1:0] res_o,
    input logic [7:0]        flags_o
);
    logic rst_q = 1'b0;
    always_ff @(posedge clk_i) rst_q <= rst_i;

    // R1
    always @(negedge clk_i) begin
        if (rst_q === 1'b1)
            reset_value_chk: assert (flags_o == 8'h02);
    end

    // R11
    fixed_bits_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (flags_o[5] == 1'b0) && (flags_o[3] == 1'b0) && (flags_o[1] == 1'b1));

    // R10
    hold_flags_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !upd_i |=> $stable(flags_o));

    // R8
    sign_capture_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        upd_i |=> flags_o[7] == $past(res_o[DATA_W-1]));

    // R7
    zero_capture_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        upd_i |=> flags_o[6] == ($past(res_o) == '0));

    // R6
    parity_capture_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        upd_i |=> flags_o[2] == ~(^$past(res_o)));

    // R9
    pass_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (upd_i && op_i[2]) |=> (flags_o[0] == 1'b0) && (flags_o[4] == 1'b0));

    // R9
    pass_result_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        op_i[2] |-> res_o == opa_i);
endmodule

bind alu_flag_gen alu_flag_gen_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .op_i    (op_i),
    .upd_i   (upd_i),
    .opa_i   (opa_i),
    .res_o   (res_o),
    .flags_o (flags_o)
);

// File: tb/alu_flag_gen_test.sv
`timescale 1ns/1ps
module alu_flag_gen_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] op  = 3'd0;
    logic [7:0] a   = 8'h00;
    logic [7:0] b   = 8'h00;
    logic       cin = 1'b0;
    logic       upd = 1'b0;
    logic [7:0] res;
    logic [7:0] flags;

    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 0;
    logic [7:0] exp_flags = 8'h02;

    always #2.5 clk = ~clk;

    alu_flag_gen uut (
        .clk_i(clk), .rst_i(rst), .op_i(op), .opa_i(a), .opb_i(b),
        .cin_i(cin), .upd_i(upd), .res_o(res), .flags_o(flags)
    );

    function automatic logic [15:0] model(input logic [2:0] o, input logic [7:0] x,
                                          input logic [7:0] y, input logic c);
        int xi, yi, ci, r;
        logic cy, ac;
        logic [7:0] rv;
        xi = int'(x); yi = int'(y); ci = int'(c);
        case (o)
            3'd0: begin r = xi + yi; cy = r > 255; ac = (xi % 16) + (yi % 16) > 15; end
            3'd1: begin r = xi + yi + ci; cy = r > 255; ac = (xi % 16) + (yi % 16) + ci > 15; end
            3'd2: begin r = xi - yi; cy = xi < yi; ac = (xi % 16) < (yi % 16); end
            3'd3: begin r = xi - yi - ci; cy = xi < yi + ci; ac = (xi % 16) < (yi % 16) + ci; end
            default: begin r = xi; cy = 1'b0; ac = 1'b0; end
        endcase
        rv = r[7:0];
        return {rv, rv[7], (rv == 8'h00), 1'b0, ac, 1'b0, ~(^rv), 1'b1, cy};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // drive one operation, check result same cycle and flags after the edge
    task automatic do_op(input string tag, input logic [2:0] o, input logic [7:0] x,
                         input logic [7:0] y, input logic c, input logic u);
        logic [15:0] m;
        @(negedge clk);
        op = o; a = x; b = y; cin = c; upd = u;
        m = model(o, x, y, c);
        #1;
        check({tag, " result"}, res, m[15:8]);
        check("R12 flags not yet updated", flags, exp_flags);
        @(posedge clk);
        #1;
        if (u) exp_flags = m[7:0];
        check({tag, " flags"}, flags, exp_flags);
        check("R11 fixed bits", flags & 8'h2A, 8'h02);
        upd = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset value", flags, 8'h02);
        @(negedge clk);
        rst = 1'b0;
        exp_flags = 8'h02;
    endtask

    task automatic t_add;
        do_op("R2 add C0+80", 3'd0, 8'hC0, 8'h80, 1'b1, 1'b1);
        check("R2 literal C0+80", flags, 8'h03);
        do_op("R2 add no carry", 3'd0, 8'h12, 8'h34, 1'b1, 1'b1);
        do_op("R2 add FF+01", 3'd0, 8'hFF, 8'h01, 1'b0, 1'b1);
    endtask

    task automatic t_adc;
        do_op("R3 adc FF+00+1", 3'd1, 8'hFF, 8'h00, 1'b1, 1'b1);
        check("R3 literal", flags, 8'h57);
        do_op("R3 adc 07+08+1", 3'd1, 8'h07, 8'h08, 1'b1, 1'b1);
    endtask

    task automatic t_aux;
        do_op("R4 aux 08+08", 3'd0, 8'h08, 8'h08, 1'b0, 1'b1);
        check("R4 literal", flags, 8'h12);
        do_op("R4 aux 04+05 none", 3'd0, 8'h04, 8'h05, 1'b0, 1'b1);
    endtask

    task automatic t_sub;
        do_op("R5 sub 10-01", 3'd2, 8'h10, 8'h01, 1'b1, 1'b1);
        check("R5 literal 10-01", flags, 8'h16);
        do_op("R5 sub 00-01", 3'd2, 8'h00, 8'h01, 1'b0, 1'b1);
        check("R5 literal 00-01", flags, 8'h97);
        do_op("R5 sbb 05-05-1", 3'd3, 8'h05, 8'h05, 1'b1, 1'b1);
        do_op("R5 sbb 80-7F-1", 3'd3, 8'h80, 8'h7F, 1'b1, 1'b1);
    endtask

    task automatic t_pass;
        for (int k = 4; k < 8; k++)
            do_op("R9 pass", 3'(k), 8'h00 + 8'(k * 37), 8'hFF, 1'b1, 1'b1);
        do_op("R9 pass zero", 3'd4, 8'h00, 8'hFF, 1'b1, 1'b1);
        check("R9 literal pass 00", flags, 8'h46);
    endtask

    task automatic t_zsp;
        do_op("R7 zero 80+80", 3'd0, 8'h80, 8'h80, 1'b0, 1'b1);
        check("R7 literal", flags, 8'h47);
        do_op("R6 parity odd", 3'd0, 8'h01, 8'h00, 1'b0, 1'b1);
        do_op("R8 sign", 3'd0, 8'h7F, 8'h01, 1'b0, 1'b1);
    endtask

    task automatic t_hold;
        do_op("R10 load", 3'd0, 8'h01, 8'h01, 1'b0, 1'b1);
        do_op("R10 hold borrow", 3'd2, 8'h00, 8'h01, 1'b0, 1'b0);
        do_op("R10 hold zero", 3'd0, 8'h80, 8'h80, 1'b0, 1'b0);
        check("R10 literal held", flags, 8'h02);
    endtask

    task automatic t_collide;
        do_op("R1 preload", 3'd2, 8'h00, 8'h01, 1'b0, 1'b1);
        @(negedge clk);
        rst = 1'b1; upd = 1'b1; op = 3'd0; a = 8'hC0; b = 8'h80;
        @(posedge clk);
        #1;
        check("R1 reset beats update", flags, 8'h02);
        @(negedge clk);
        rst = 1'b0; upd = 1'b0;
        exp_flags = 8'h02;
    endtask

    task automatic t_random;
        for (int i = 0; i < 1500; i++)
            do_op("R2 R3 R5 R6 R7 R8 R9 R10 random", 3'($urandom_range(0, 7)),
                  8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
    endtask

    initial begin
        t_reset();
        t_add();
        t_adc();
        t_aux();
        t_sub();
        t_pass();
        t_zsp();
        t_hold();
        t_collide();
        t_random();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule